// File: doc/BRIEF.md
# Carry Flag with Interrupt Save Stack

This block holds the single carry/borrow flag of a small processor core. Whenever the arithmetic unit reports a result, the flag is loaded with "carry or borrow". Next to the flag sits a four-level save stack with a 2-bit pointer, so the flag survives nested interrupt service routines without any software action. When an interrupt is accepted, the current flag is stored in the slot the pointer selects and the pointer then steps forward. A return from interrupt steps the pointer back and reloads the flag from that slot.

Software reaches the flag, the pointer and every stack slot through a narrow 4-bit port. The port has one address each for the flag and for the pointer, plus one address per slot. This lets a debugger or a context switcher inspect or rebuild the stack. The only continuous output is the flag itself. Several events can arrive in the same cycle, so fixed priorities settle each register. Each cycle, the top decodes one of four stack operations (HOLD, SAVE, RESTORE, PORT) and one of four flag sources (HOLD, RESTORE, ALU, PORT). There is no state beyond the registers: the "transitions" are these per-cycle operation choices.

Top module: `carry_save_stack`

## Requirements
- R1: Asynchronous active-low reset clears the flag, the pointer and all four stack slots; afterwards every mapped port address reads 0.
- R2: A cycle with `alu_upd` high and `int_ret` low sets the flag to `alu_carry | alu_borrow` at the next clock edge.
- R3: A port write to address 0 loads the flag from `port_wdata[0]`. A port read of address 0 returns the flag in bit 0 and zeros in bits 3..1. Without an ALU update, return or flag write, the flag holds.
- R4: When an ALU update and a port write to address 0 occur in the same cycle, the ALU result wins.
- R5: An interrupt accept (`int_take` high, `int_ret` low) stores the flag value from before the edge into slot[pointer] and increments the pointer.
- R6: A return (`int_ret` high) decrements the pointer and loads the flag from the slot at the decremented pointer, so it reads back the most recent save.
- R7: The pointer wraps modulo 4 in both directions (3+1 = 0, 0-1 = 3), with no error indication.
- R8: A port write to address 1 loads the pointer from `port_wdata[1:0]`. A port read of address 1 returns the pointer in bits 1..0 and zeros above.
- R9: Port addresses 4, 5, 6 and 7 map to slots 0..3. A write loads the slot from `port_wdata[0]`, and a read returns the slot in bit 0.
- R10: When `int_take` and `int_ret` are high together, only the return takes effect. No slot is written, and the pointer only decrements.
- R11: A save or return blocks port writes to the pointer and to the slots in that cycle. A return also takes priority over both the ALU update and a port flag write.
- R12: Addresses 2 and 3 read as 0 and ignore writes. `port_rdata` is 0 whenever `port_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_upd | input | 1 | Arithmetic result strobe |
| alu_carry | input | 1 | Carry out of the arithmetic result |
| alu_borrow | input | 1 | Borrow out of the arithmetic result |
| int_take | input | 1 | Interrupt accepted strobe |
| int_ret | input | 1 | Return-from-interrupt strobe |
| port_wr | input | 1 | Software port write strobe |
| port_rd | input | 1 | Software port read enable |
| port_addr | input | 3 | Port address |
| port_wdata | input | 4 | Port write data |
| port_rdata | output | 4 | Port read data (combinational) |
| carry_o | output | 1 | Current carry flag |

## Verification
The assertions watch, on every cycle, the next flag value after an ALU update, pointer movement on save, return and port write, holding of flag and pointer when nothing addresses them, and the idle read bus. Only the bench scenarios can show which value lands in which slot and comes back on a return. The same is true of wrap-around nesting, priority between simultaneous events, and the effect of writes to unmapped addresses. The bench covers these by comparing a behavioural model against the ports in every cycle.

// File: rtl/csk_pkg.sv
package csk_pkg;
    // Per-cycle operation applied to the pointer and the slots
    typedef enum logic [1:0] {
        STK_HOLD,
        STK_SAVE,
        STK_RESTORE,
        STK_PORT
    } stk_op_e;

    // Source selected for the flag register
    typedef enum logic [1:0] {
        FSRC_HOLD,
        FSRC_RESTORE,
        FSRC_ALU,
        FSRC_PORT
    } flag_src_e;

    // What a port address points at
    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_FLAG,
        TGT_PTR,
        TGT_ENTRY
    } port_tgt_e;
endpackage

// File: rtl/csk_port_dec.sv
module csk_port_dec
    import csk_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DEPTH      = 4,
    parameter int FLAG_ADDR  = 0,
    parameter int PTR_ADDR   = 1,
    parameter int ENTRY_BASE = 4,
    localparam int PTR_W     = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output port_tgt_e         tgt,
    output logic [PTR_W-1:0]  idx
);
    localparam int ENTRY_END = ENTRY_BASE + DEPTH;

    always_comb begin
        tgt = TGT_NONE;
        idx = '0;
        if (int'(addr) == FLAG_ADDR) begin
            tgt = TGT_FLAG;
        end else if (int'(addr) == PTR_ADDR) begin
            tgt = TGT_PTR;
        end else if (int'(addr) >= ENTRY_BASE && int'(addr) < ENTRY_END) begin
            tgt = TGT_ENTRY;
            idx = PTR_W'(int'(addr) - ENTRY_BASE);
        end
    end
endmodule

// File: rtl/csk_stack.sv
module csk_stack
    import csk_pkg::*;
#(
    parameter int DEPTH  = 4,  // power of two: the pointer wraps by width
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    input  port_tgt_e        tgt,
    input  logic [PTR_W-1:0] port_idx,
    input  logic [PTR_W-1:0] port_ptr,
    input  logic             port_bit,
    input  logic             cur_flag,
    output logic [PTR_W-1:0] ptr_q,
    output logic [DEPTH-1:0] ent_q,
    output logic             restore_bit
);
    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_inc;

    assign ptr_dec     = ptr_q - PTR_W'(1);
    assign ptr_inc     = ptr_q + PTR_W'(1);
    assign restore_bit = ent_q[ptr_dec];

    // Pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            unique case (op)
                STK_SAVE:    ptr_q <= ptr_inc;
                STK_RESTORE: ptr_q <= ptr_dec;
                STK_PORT:    if (tgt == TGT_PTR) ptr_q <= port_ptr;
                STK_HOLD:    ;
            endcase
        end
    end

    // Save slots
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[i] <= 1'b0;
            end else begin
                unique case (op)
                    STK_SAVE:    if (ptr_q == PTR_W'(i)) ent_q[i] <= cur_flag;
                    STK_PORT:    if (tgt == TGT_ENTRY && port_idx == PTR_W'(i)) ent_q[i] <= port_bit;
                    STK_RESTORE: ;
                    STK_HOLD:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/csk_flag.sv
module csk_flag
    import csk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_src_e src,
    input  logic      restore_bit,
    input  logic      alu_bit,
    input  logic      port_bit,
    output logic      flag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            unique case (src)
                FSRC_RESTORE: flag_q <= restore_bit;
                FSRC_ALU:     flag_q <= alu_bit;
                FSRC_PORT:    flag_q <= port_bit;
                FSRC_HOLD:    ;
            endcase
        end
    end
endmodule

// File: rtl/carry_save_stack.sv
module carry_save_stack
    import csk_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int DATA_W     = 4,
    parameter int ADDR_W     = 3,
    parameter int FLAG_ADDR  = 0,
    parameter int PTR_ADDR   = 1,
    parameter int ENTRY_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_upd,
    input  logic              alu_carry,
    input  logic              alu_borrow,
    input  logic              int_take,
    input  logic              int_ret,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] port_wdata,
    output logic [DATA_W-1:0] port_rdata,
    output logic              carry_o
);
    localparam int PTR_W = $clog2(DEPTH);

    port_tgt_e        tgt;
    logic [PTR_W-1:0] idx;
    logic [PTR_W-1:0] ptr_q;
    logic [DEPTH-1:0] ent_q;
    logic             restore_bit;
    logic             flag_q;
    stk_op_e          stk_op;
    flag_src_e        fsrc;
    logic             unused_wdata;

    assign unused_wdata = ^port_wdata;

    csk_port_dec #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .FLAG_ADDR(FLAG_ADDR),
        .PTR_ADDR(PTR_ADDR), .ENTRY_BASE(ENTRY_BASE)
    ) u_dec (
        .addr(port_addr), .tgt(tgt), .idx(idx)
    );

    // Stack operation: return beats save, both beat software writes
    always_comb begin
        if (int_ret)
            stk_op = STK_RESTORE;
        else if (int_take)
            stk_op = STK_SAVE;
        else if (port_wr && (tgt == TGT_PTR || tgt == TGT_ENTRY))
            stk_op = STK_PORT;
        else
            stk_op = STK_HOLD;
    end

    // Flag source: return, then arithmetic, then software write
    always_comb begin
        if (int_ret)
            fsrc = FSRC_RESTORE;
        else if (alu_upd)
            fsrc = FSRC_ALU;
        else if (port_wr && tgt == TGT_FLAG)
            fsrc = FSRC_PORT;
        else
            fsrc = FSRC_HOLD;
    end

    csk_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .op(stk_op), .tgt(tgt),
        .port_idx(idx), .port_ptr(port_wdata[PTR_W-1:0]),
        .port_bit(port_wdata[0]), .cur_flag(flag_q),
        .ptr_q(ptr_q), .ent_q(ent_q), .restore_bit(restore_bit)
    );

    csk_flag u_flag (
        .clk(clk), .rst_n(rst_n), .src(fsrc), .restore_bit(restore_bit),
        .alu_bit(alu_carry | alu_borrow), .port_bit(port_wdata[0]),
        .flag_q(flag_q)
    );

    // Read path
    always_comb begin
        port_rdata = '0;
        if (port_rd) begin
            unique case (tgt)
                TGT_FLAG:  port_rdata = DATA_W'(flag_q);
                TGT_PTR:   port_rdata = DATA_W'(ptr_q);
                TGT_ENTRY: port_rdata = DATA_W'(ent_q[idx]);
                TGT_NONE:  port_rdata = '0;
            endcase
        end
    end

    assign carry_o = flag_q;
endmodule

// File: rtl/csk_checker.sv
module csk_checker #(
    parameter int DATA_W    = 4,
    parameter int ADDR_W    = 3,
    parameter int PTR_W     = 2,
    parameter int FLAG_ADDR = 0,
    parameter int PTR_ADDR  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alu_upd,
    input logic              alu_carry,
    input logic              alu_borrow,
    input logic              int_take,
    input logic              int_ret,
    input logic              port_wr,
    input logic              port_rd,
    input logic [ADDR_W-1:0] port_addr,
    input logic [PTR_W-1:0]  port_ptr_bits,
    input logic [DATA_W-1:0] port_rdata,
    input logic              carry_o,
    input logic [PTR_W-1:0]  ptr_q
);
    logic wr_flag, wr_ptr;
    assign wr_flag = port_wr && (int'(port_addr) == FLAG_ADDR);
    assign wr_ptr  = port_wr && (int'(port_addr) == PTR_ADDR);

    p_alu_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alu_upd && !int_ret |=> carry_o == $past(alu_carry | alu_borrow));

    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_upd && !int_ret && !wr_flag |=> $stable(carry_o));

    p_save_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_take && !int_ret |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));

    p_restore_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_ret |=> ptr_q == PTR_W'($past(ptr_q) - PTR_W'(1)));

    p_ptr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr && !int_take && !int_ret |=> ptr_q == $past(port_ptr_bits));

    p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !int_take && !int_ret && !wr_ptr |=> $stable(ptr_q));

    p_idle_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rd |-> port_rdata == '0);
endmodule

bind carry_save_stack csk_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
    .FLAG_ADDR(FLAG_ADDR), .PTR_ADDR(PTR_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_carry(alu_carry),
    .alu_borrow(alu_borrow), .int_take(int_take), .int_ret(int_ret),
    .port_wr(port_wr), .port_rd(port_rd), .port_addr(port_addr),
    .port_ptr_bits(port_wdata[PTR_W-1:0]), .port_rdata(port_rdata),
    .carry_o(carry_o), .ptr_q(ptr_q)
);

// File: tb/carry_save_stack_tb.sv
`timescale 1ns/100ps
module carry_save_stack_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alu_upd = 0, alu_carry = 0, alu_borrow = 0;
    logic       int_take = 0, int_ret = 0, port_wr = 0, port_rd = 0;
    logic [2:0] port_addr = '0;
    logic [3:0] port_wdata = '0;
    logic [3:0] port_rdata;
    logic       carry_o;

    always #2.5 clk = ~clk;

    carry_save_stack u_dut (
        .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_carry(alu_carry),
        .alu_borrow(alu_borrow), .int_take(int_take), .int_ret(int_ret),
        .port_wr(port_wr), .port_rd(port_rd), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata), .carry_o(carry_o)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // Behavioural reference
    bit m_flag;
    int m_ptr;
    bit m_ent[4];

    function automatic void model_reset();
        m_flag = 0; m_ptr = 0;
        foreach (m_ent[i]) m_ent[i] = 0;
    endfunction

    function automatic int model_read(bit rd, int a);
        if (!rd) return 0;
        if (a == 0) return int'(m_flag);
        if (a == 1) return m_ptr;
        if (a >= 4 && a <= 7) return int'(m_ent[a-4]);
        return 0;
    endfunction

    function automatic void model_step(bit au, bit ac, bit ab, bit tk, bit rt,
                                       bit wr, int a, int wd);
        int nptr = m_ptr;
        bit nf = m_flag;
        if (rt) begin
            nptr = (m_ptr + 3) % 4;
            nf = m_ent[nptr];
        end else begin
            if (tk) begin
                m_ent[m_ptr] = m_flag;
                nptr = (m_ptr + 1) % 4;
            end
            if (au) nf = ac | ab;
            else if (wr && a == 0) nf = bit'(wd & 1);
            if (!tk && wr) begin
                if (a == 1) nptr = wd % 4;
                else if (a >= 4 && a <= 7) m_ent[a-4] = bit'(wd & 1);
            end
        end
        m_ptr = nptr;
        m_flag = nf;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check read bus, clock, check flag
    task automatic step(string tag, bit au, bit ac, bit ab, bit tk, bit rt,
                        bit wr, bit rd, int a, int wd);
        alu_upd = au; alu_carry = ac; alu_borrow = ab;
        int_take = tk; int_ret = rt; port_wr = wr; port_rd = rd;
        port_addr = 3'(a); port_wdata = 4'(wd);
        #1;
        chk({tag, " rdata"}, int'(port_rdata), model_read(rd, a));
        @(posedge clk);
        model_step(au, ac, ab, tk, rt, wr, a, wd);
        @(negedge clk);
        chk({tag, " flag"}, int'(carry_o), int'(m_flag));
    endtask

    task automatic alu(string t, bit c, bit b); step(t, 1, c, b, 0, 0, 0, 0, 0, 0); endtask
    task automatic pw(string t, int a, int d);  step(t, 0, 0, 0, 0, 0, 1, 0, a, d); endtask
    task automatic pr(string t, int a);         step(t, 0, 0, 0, 0, 0, 0, 1, a, 0); endtask
    task automatic save(string t);              step(t, 0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
    task automatic back(string t);              step(t, 0, 0, 0, 0, 1, 0, 0, 0, 0); endtask

    task automatic read_all(string t);
        pr(t, 0); pr(t, 1);
        for (int k = 4; k < 8; k++) pr(t, k);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {alu_upd, alu_carry, alu_borrow, int_take, int_ret, port_wr, port_rd} = '0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R1: everything reads zero after reset
        read_all("R1");

        // R2: carry or borrow
        alu("R2", 1, 0); alu("R2", 0, 0); alu("R2", 0, 1);
        alu("R2", 1, 1); alu("R2", 0, 0);

        // R3: software flag access
        pw("R3", 0, 1); pr("R3", 0);
        pw("R3", 0, 4'hE); pr("R3", 0);
        step("R3 hold", 0, 0, 0, 0, 0, 0, 1, 0, 0);

        // R4: ALU beats port write
        step("R4", 1, 0, 0, 0, 0, 1, 0, 0, 1);
        step("R4", 1, 1, 0, 0, 0, 1, 0, 0, 0);

        // R5: nested saves
        alu("R5", 1, 0); save("R5");
        alu("R5", 0, 0); save("R5");
        alu("R5", 1, 0); save("R5");
        alu("R5", 0, 0);
        read_all("R5");

        // R6: restores return most recent saves
        back("R6"); back("R6"); back("R6");
        pr("R6", 1);

        // R7: wrap both ways
        pw("R7", 1, 3); alu("R7", 1, 0); save("R7"); pr("R7", 1);
        back("R7"); pr("R7", 1);
        pw("R7", 1, 0); back("R7"); pr("R7", 1);
        for (int k = 0; k < 5; k++) begin alu("R7", 1, 1); save("R7"); end
        read_all("R7");

        // R8: pointer write keeps two bits
        pw("R8", 1, 4'hF); pr("R8", 1);
        pw("R8", 1, 4'h6); pr("R8", 1);

        // R9: slot access and use by a return
        pw("R9", 4, 1); pw("R9", 5, 0); pw("R9", 6, 1); pw("R9", 7, 0);
        read_all("R9");
        pw("R9", 7, 4'hB); pw("R9", 1, 0); back("R9"); pr("R9", 1);

        // R10: take and return together
        pw("R10", 1, 2); alu("R10", 1, 0);
        step("R10", 0, 0, 0, 1, 1, 0, 0, 0, 0);
        read_all("R10");

        // R11: hardware events block software writes
        pw("R11", 1, 0); alu("R11", 1, 0);
        step("R11", 0, 0, 0, 1, 0, 1, 0, 4, 0);
        step("R11", 0, 0, 0, 1, 0, 1, 0, 1, 3);
        read_all("R11");
        step("R11", 1, 1, 1, 0, 1, 0, 0, 0, 0);
        step("R11", 0, 0, 0, 0, 1, 1, 0, 0, 1);
        step("R11", 0, 0, 0, 0, 1, 1, 0, 5, 1);
        read_all("R11");

        // R12: unmapped addresses and idle bus
        pw("R12", 2, 4'hF); pw("R12", 3, 4'hF);
        pr("R12", 2); pr("R12", 3);
        alu("R12", 1, 0);
        step("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        read_all("R12");

        // Mixed traffic, R2 R5 R6 combined
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom;
            step("R2 R5 R6 mix", bit'(r[0]), bit'(r[1]), bit'(r[2]),
                 bit'(r[3] & r[4]), bit'(r[5] & r[6]), bit'(r[7]),
                 bit'(r[8]), int'(r[11:9]), int'(r[15:12]));
        end

        // R1: reset in the middle of activity
        do_reset();
        read_all("R1 mid");

        finished = 1;
        summary();
        $finish;
    end
endmodule